// File: doc/BRIEF.md
# LIN Frame Status and Interrupt Unit

This block keeps the frame-level status of a LIN controller and folds it into a single interrupt line. The serial engine reports three kinds of success as single-cycle pulses: identifier accepted, response transmitted and response received. It also reports eight error causes as pulses on an error vector. Each pulse sets a sticky bit. Software reads these bits through a small four-register interface and clears them by writing ones.

The eight error bits collapse into one summary error flag. That flag sits beside the three success flags, and each of the four flags has its own enable bit. On every identifier strobe the unit also classifies the received 6-bit identifier. Only the reserved values 60 to 63 get a specific 3-bit code, and every other identifier reads as "no specific identifier". Frames with those reserved identifiers use the classic checksum, which covers the data bytes only. A software mode bit selects whether the identifier joins the checksum. The unit samples that bit into a registered output when a transmit-response or receive-response command starts, so the checksum engine sees one stable choice for the whole response.

Top module: `lin_status_irq`

Register map (2-bit `reg_addr`):
- 0, status: bit0 receive done, bit1 transmit done, bit2 identifier accepted, bit3 summary error, bit4 reads 0, bits7:5 identifier code. Writing 1 to bits 0 to 2 clears that flag. Writing 1 to bit3 clears all eight error bits.
- 1, errors (read only): bit0 bit error, bit1 checksum, bit2 parity, bit3 sync, bit4 frame, bit5 overrun, bit6 timeout, bit7 abort. The `err_evt` input uses the same bit positions.
- 2, enables: bits3:0 enable the flags at status bits 3:0.
- 3, control: bit0 set to 1 includes the identifier in the checksum (enhanced), set to 0 leaves it out (classic).

## Requirements
- R1: After synchronous reset, all flags, error bits, enables, the identifier code, the mode bit and `csum_incl_id` are 0, and `irq` is 0.
- R2: A pulse on `evt_rx_ok`, `evt_tx_ok` or `evt_id_ok` sets status bit 0, 1 or 2 respectively from the next cycle on.
- R3: Writing 1 to status bits 0 to 2 clears those flags and writing 0 leaves them unchanged. If a set pulse arrives in the same cycle as a clear, the flag stays set.
- R4: Each `err_evt[k]` pulse sets error bit k, and the bit then holds. Writes to the error register have no effect.
- R5: Status bit 3 reads as the OR of the eight error bits. Writing 1 to status bit 3 clears every error bit except one whose pulse arrives in that same cycle.
- R6: `irq` is 1 exactly when some status flag among bits 3:0 is 1 and its enable bit is also 1.
- R7: On `id_valid`, the identifier code becomes 3'b1xx with xx = `id_value[1:0]` when `id_value` is 60 to 63, and 3'b000 otherwise. The code holds between strobes and appears on `id_code` and in status bits 7:5.
- R8: On `resp_cmd_start`, `csum_incl_id` takes the value the mode bit held before that edge. At all other times it holds, whatever is written to the mode bit.
- R9: The enable and control registers read back what was written in their defined bits, and their undefined bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_rx_ok | input | 1 | Response received pulse |
| evt_tx_ok | input | 1 | Response transmitted pulse |
| evt_id_ok | input | 1 | Identifier accepted pulse |
| err_evt | input | 8 | Error cause pulses, positions as in the error register |
| id_value | input | 6 | Received identifier |
| id_valid | input | 1 | Strobe qualifying `id_value` |
| resp_cmd_start | input | 1 | Pulse when a transmit or receive response command starts |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined interrupt |
| id_code | output | 3 | Identifier status code |
| csum_incl_id | output | 1 | Sampled checksum mode, 1 = identifier included |

## Verification
The bench targets a set pulse and a write-one clear landing in the same cycle. A design that let the clear win would drop an event and read the flag as 0. It clears the summary error flag while a new error pulse arrives, which catches a clear that wipes the fresh cause too. It walks the identifiers 59 to 64, where a decoder off by one at either boundary would return a wrong code. It also toggles the mode bit between response starts, where a transparent mode path would move `csum_incl_id` in the middle of a frame.

// File: rtl/lin_stat_pkg.sv
package lin_stat_pkg;

    localparam int DATA_W  = 8;
    localparam int ERR_W   = 8;
    localparam int ID_W    = 6;
    localparam int NUM_EVT = 3;
    localparam int ADDR_W  = 2;
    localparam int CODE_W  = 3;

    // first reserved identifier; the four reserved ones share the upper bits
    localparam logic [ID_W-1:0] RSVD_ID_BASE = 6'd60;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_ERROR  = 2'd1,
        REG_ENABLE = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              rsvd;
        logic              err_sum;
        logic              id_ok;
        logic              tx_ok;
        logic              rx_ok;
    } status_t;

    function automatic logic [CODE_W-1:0] id_status_code(input logic [ID_W-1:0] id);
        if (id[ID_W-1:2] == RSVD_ID_BASE[ID_W-1:2])
            return {1'b1, id[1:0]};
        return '0;
    endfunction

endpackage

// File: rtl/lin_sticky_bit.sv
module lin_sticky_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/lin_id_status.sv
module lin_id_status
    import lin_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              id_valid,
    input  logic [ID_W-1:0]   id_value,
    output logic [CODE_W-1:0] code_o
);
    always_ff @(posedge clk) begin
        if (rst)           code_o <= '0;
        else if (id_valid) code_o <= id_status_code(id_value);
    end
endmodule

// File: rtl/lin_csum_sel.sv
module lin_csum_sel (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic mode_i,
    output logic incl_o
);
    always_ff @(posedge clk) begin
        if (rst)          incl_o <= 1'b0;
        else if (start_i) incl_o <= mode_i;
    end
endmodule

// File: rtl/lin_status_irq.sv
module lin_status_irq
    import lin_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_rx_ok,
    input  logic              evt_tx_ok,
    input  logic              evt_id_ok,
    input  logic [ERR_W-1:0]  err_evt,
    input  logic [ID_W-1:0]   id_value,
    input  logic              id_valid,
    input  logic              resp_cmd_start,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic [CODE_W-1:0] id_code,
    output logic              csum_incl_id
);
    localparam int NUM_FLAG = NUM_EVT + 1;

    reg_sel_e            sel;
    logic                wr_status;
    logic [NUM_EVT-1:0]  evt_vec;
    logic [NUM_EVT-1:0]  flags_q;
    logic [ERR_W-1:0]    err_q;
    logic                err_clr;
    logic                err_sum;
    logic [NUM_FLAG-1:0] en_q;
    logic                mode_q;
    status_t             stat;

    assign sel       = reg_sel_e'(reg_addr);
    assign wr_status = reg_wr && (sel == REG_STATUS);
    assign evt_vec   = {evt_id_ok, evt_tx_ok, evt_rx_ok};
    assign err_clr   = wr_status && reg_wdata[NUM_EVT];

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
        lin_sticky_bit u_flag (
            .clk  (clk),
            .rst  (rst),
            .set_i(evt_vec[i]),
            .clr_i(wr_status && reg_wdata[i]),
            .q_o  (flags_q[i])
        );
    end

    for (genvar k = 0; k < ERR_W; k++) begin : g_err
        lin_sticky_bit u_err (
            .clk  (clk),
            .rst  (rst),
            .set_i(err_evt[k]),
            .clr_i(err_clr),
            .q_o  (err_q[k])
        );
    end

    assign err_sum = |err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mode_q <= 1'b0;
        end else if (reg_wr) begin
            if (sel == REG_ENABLE) en_q   <= reg_wdata[NUM_FLAG-1:0];
            if (sel == REG_CTRL)   mode_q <= reg_wdata[0];
        end
    end

    lin_id_status u_id (
        .clk     (clk),
        .rst     (rst),
        .id_valid(id_valid),
        .id_value(id_value),
        .code_o  (id_code)
    );

    lin_csum_sel u_csum (
        .clk    (clk),
        .rst    (rst),
        .start_i(resp_cmd_start),
        .mode_i (mode_q),
        .incl_o (csum_incl_id)
    );

    always_comb begin
        stat         = '0;
        stat.rx_ok   = flags_q[0];
        stat.tx_ok   = flags_q[1];
        stat.id_ok   = flags_q[2];
        stat.err_sum = err_sum;
        stat.code    = id_code;
    end

    assign irq = |({err_sum, flags_q} & en_q);

    always_comb begin
        reg_rdata = '0;
        case (sel)
            REG_STATUS: reg_rdata = stat;
            REG_ERROR:  reg_rdata = err_q;
            REG_ENABLE: reg_rdata[NUM_FLAG-1:0] = en_q;
            REG_CTRL:   reg_rdata[0] = mode_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lin_status_chk.sv
module lin_status_chk
    import lin_stat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              evt_rx_ok,
    input logic              evt_tx_ok,
    input logic              evt_id_ok,
    input logic [ERR_W-1:0]  err_evt,
    input logic [ID_W-1:0]   id_value,
    input logic              id_valid,
    input logic              resp_cmd_start,
    input logic              irq,
    input logic [CODE_W-1:0] id_code,
    input logic              csum_incl_id,
    input logic [NUM_EVT-1:0] flags_q,
    input logic [ERR_W-1:0]  err_q,
    input logic [NUM_EVT:0]  en_q,
    input logic              mode_q
);
    assert_rx_set_R2: assert property (@(posedge clk) disable iff (rst)
        evt_rx_ok |=> flags_q[0]);
    assert_tx_set_R2: assert property (@(posedge clk) disable iff (rst)
        evt_tx_ok |=> flags_q[1]);
    assert_id_set_R3: assert property (@(posedge clk) disable iff (rst)
        evt_id_ok |=> flags_q[2]);   // set wins over a same-cycle clear
    assert_err_set_R4: assert property (@(posedge clk) disable iff (rst)
        (|err_evt) |=> ((err_q & $past(err_evt)) == $past(err_evt)));
    assert_err_irq_R5: assert property (@(posedge clk) disable iff (rst)
        ((|err_q) && en_q[3]) |-> irq);
    assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq);
    assert_id_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !id_valid |=> $stable(id_code));
    assert_id_plain_R7: assert property (@(posedge clk) disable iff (rst)
        (id_valid && (id_value < 6'd60)) |=> (id_code == 3'b000));
    assert_csum_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !resp_cmd_start |=> $stable(csum_incl_id));
    assert_csum_take_R8: assert property (@(posedge clk) disable iff (rst)
        resp_cmd_start |=> (csum_incl_id == $past(mode_q)));
endmodule

bind lin_status_irq lin_status_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .evt_rx_ok     (evt_rx_ok),
    .evt_tx_ok     (evt_tx_ok),
    .evt_id_ok     (evt_id_ok),
    .err_evt       (err_evt),
    .id_value      (id_value),
    .id_valid      (id_valid),
    .resp_cmd_start(resp_cmd_start),
    .irq           (irq),
    .id_code       (id_code),
    .csum_incl_id  (csum_incl_id),
    .flags_q       (flags_q),
    .err_q         (err_q),
    .en_q          (en_q),
    .mode_q        (mode_q)
);

// File: tb/sim_lin_status_irq.sv
module sim_lin_status_irq;
    logic       clk = 1'b0;
    logic       rst;
    logic       evt_rx_ok, evt_tx_ok, evt_id_ok;
    logic [7:0] err_evt;
    logic [5:0] id_value;
    logic       id_valid, resp_cmd_start;
    logic [1:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq;
    logic [2:0] id_code;
    logic       csum_incl_id;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state
    logic [2:0] m_flags;
    logic [7:0] m_err;
    logic [3:0] m_en;
    logic       m_mode, m_incl;
    logic [2:0] m_code;

    always #2.5 clk = ~clk;

    lin_status_irq u0 (
        .clk(clk), .rst(rst),
        .evt_rx_ok(evt_rx_ok), .evt_tx_ok(evt_tx_ok), .evt_id_ok(evt_id_ok),
        .err_evt(err_evt), .id_value(id_value), .id_valid(id_valid),
        .resp_cmd_start(resp_cmd_start), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .id_code(id_code), .csum_incl_id(csum_incl_id)
    );

    function automatic logic [2:0] exp_code(input logic [5:0] id);
        return (id >= 6'd60) ? {1'b1, id[1:0]} : 3'b000;
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {m_code, 1'b0, |m_err, m_flags};
            2'd1:    return m_err;
            2'd2:    return {4'b0, m_en};
            default: return {7'b0, m_mode};
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic rx, input logic tx, input logic idok,
                       input logic [7:0] ee, input logic idv, input logic [5:0] idval,
                       input logic start, input logic wr, input logic [1:0] a,
                       input logic [7:0] wd);
        logic [3:0] clr;
        evt_rx_ok = rx; evt_tx_ok = tx; evt_id_ok = idok; err_evt = ee;
        id_valid = idv; id_value = idval; resp_cmd_start = start;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        clr = (wr && a == 2'd0) ? wd[3:0] : 4'b0;
        @(posedge clk);
        m_flags = {idok, tx, rx} | (m_flags & ~clr[2:0]);
        m_err   = ee | (m_err & {8{~clr[3]}});
        if (start) m_incl = m_mode;
        if (wr && a == 2'd2) m_en = wd[3:0];
        if (wr && a == 2'd3) m_mode = wd[0];
        if (idv) m_code = exp_code(idval);
        @(negedge clk);
        check("R6 irq", {7'b0, irq}, {7'b0, |({|m_err, m_flags} & m_en)});
        check("R7 id_code", {5'b0, id_code}, {5'b0, m_code});
        check("R8 csum_incl_id", {7'b0, csum_incl_id}, {7'b0, m_incl});
        case (a)
            2'd0:    check("R3/R5 status read", reg_rdata, exp_read(a));
            2'd1:    check("R4 error read", reg_rdata, exp_read(a));
            default: check("R9 cfg read", reg_rdata, exp_read(a));
        endcase
    endtask

    task automatic idle(input logic [1:0] a);
        cyc(0, 0, 0, 8'h00, 0, 6'd0, 0, 0, a, 8'h00);
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_flags = '0; m_err = '0; m_en = '0; m_mode = 0; m_incl = 0; m_code = '0;
        evt_rx_ok = 0; evt_tx_ok = 0; evt_id_ok = 0; err_evt = 0; id_valid = 0;
        id_value = 0; resp_cmd_start = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #0.1;
            check("R1 reset read", reg_rdata, 8'h00);
        end
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 code/incl", {4'b0, id_code, csum_incl_id}, 8'h00);

        // R2 each event sets its flag
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 2'd0, 0);
        check("R2 rx flag", {7'b0, reg_rdata[0]}, 8'h01);
        cyc(0, 1, 1, 0, 0, 0, 0, 0, 2'd0, 0);
        check("R2 tx/id flags", {5'b0, reg_rdata[2:0]}, 8'h07);
        // R3 write zero keeps, set beats clear, clear alone clears
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 8'h00);
        check("R3 write zero", {5'b0, reg_rdata[2:0]}, 8'h07);
        cyc(1, 0, 0, 0, 0, 0, 0, 1, 2'd0, 8'h07);
        check("R3 set wins", {5'b0, reg_rdata[2:0]}, 8'h01);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 8'h01);
        check("R3 clear", {5'b0, reg_rdata[2:0]}, 8'h00);
        // R4 errors and ignored write
        cyc(0, 0, 0, 8'h81, 0, 0, 0, 1, 2'd1, 8'h00);
        check("R4 err bits", reg_rdata, 8'h81);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 2'd1, 8'hFF);
        check("R4 write ignored", reg_rdata, 8'h81);
        // R6 enable summary -> irq
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 8'h08);
        check("R6 irq on err", {7'b0, irq}, 8'h01);
        // R5 clear summary with fresh error same cycle
        cyc(0, 0, 0, 8'h04, 0, 0, 0, 1, 2'd0, 8'h08);
        check("R5 summary kept", {7'b0, reg_rdata[3]}, 8'h01);
        idle(2'd1);
        check("R5 only fresh bit", reg_rdata, 8'h04);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 8'h08);
        check("R5 summary cleared", {7'b0, reg_rdata[3]}, 8'h00);
        check("R6 irq low", {7'b0, irq}, 8'h00);
        // R7 identifier boundaries
        for (int id = 59; id <= 64; id++) begin
            cyc(0, 0, 0, 0, 1, 6'(id), 0, 0, 2'd0, 0);
            check("R7 decode", {5'b0, id_code}, {5'b0, exp_code(6'(id))});
        end
        idle(2'd0);
        check("R7 hold", {5'b0, reg_rdata[7:5]}, {5'b0, exp_code(6'(64))});
        // R8 latch on start only
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 2'd3, 8'hFF);
        check("R9 ctrl read", reg_rdata, 8'h01);
        check("R8 no start", {7'b0, csum_incl_id}, 8'h00);
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 2'd3, 8'h00);
        check("R8 takes old mode", {7'b0, csum_incl_id}, 8'h01);
        idle(2'd3);
        check("R8 holds", {7'b0, csum_incl_id}, 8'h01);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] ee;
            ee = ($urandom % 6 == 0) ? (8'h01 << ($urandom % 8)) : 8'h00;
            cyc($urandom % 4 == 0, $urandom % 5 == 0, $urandom % 5 == 0, ee,
                $urandom % 3 == 0, 6'($urandom % 64), $urandom % 7 == 0,
                $urandom % 3 == 0, 2'($urandom % 4), 8'($urandom));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule